// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block is the serial control port of a clock-generator controller. A host on a two-wire serial bus (SCL and SDA, open drain) talks to it through six 8-bit configuration registers. The block oversamples both bus lines with its own fast clock, so it needs no clock domain tied to SCL. It recognises start and stop conditions and matches its 7-bit device address. It pulls SDA low for acknowledge bits and for the zero bits of the data it returns.

A write begins with two framing bytes, a command code and a byte count. The slave acknowledges both and then discards them. Every later byte lands in the next register, starting at register 0. A read returns a byte count first and then the register contents in ascending order.

The register contents are decoded into control outputs:
- a 4-bit frequency code, taken either from strap pins latched after reset or from register bits;
- a spread-spectrum enable and a spread-mode select;
- a global tristate request;
- four 8-bit per-output enable masks.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register 0 is 0x20 (frequency bits code 0010, every other bit 0). Registers 1, 2, 3 and 5 are 0xFF. The writable bits of register 4 are 1. All enable masks therefore read all ones, and spread, spread mode and tristate are 0.
- R2: The write address byte 0xD2 and the read address byte 0xD3 are acknowledged (SDA low in the ninth bit). Any other address byte is not acknowledged, and the slave then ignores the bus until the next start condition.
- R3: In a write, the two bytes after the address are acknowledged and discarded. The following bytes load register 0, then register 1, and so on up to register 5, and each of them is acknowledged.
- R4: A stop condition after any complete byte ends a write. Registers already written keep their new values, and all other registers are unchanged.
- R5: Data bytes after the sixth one in a write are acknowledged and change no register.
- R6: In a read, the slave first sends the byte count 6 and then registers 0 to 5 in order, moving on after each master acknowledge. It stops driving after a master non-acknowledge. Any byte requested after register 5 reads 0xFF.
- R7: The strap inputs are captured on the first clock after reset is released. Register 4 reads bit 3 as the inverted strap bit 1 and bit 1 as the inverted strap bit 3. These two bits cannot be written.
- R8: When register 0 bit 3 is 0, `freq_code` equals the latched strap value. When it is 1, `freq_code` is {bit 2, bit 6, bit 5, bit 4} of register 0, with bit 2 as the most significant bit.
- R9: `spread_en` follows register 0 bit 1, `spread_down` follows bit 7 (1 selects down spread, 0 selects center spread) and `outs_tristate` follows bit 0.
- R10: `cpu_en`, `pci_en`, `sdr_en` and `per_en` equal registers 1, 2, 3 and 5 bit for bit. A 1 enables an output and a 0 holds it low.
- R11: A start or stop condition in the middle of a byte aborts the transfer and writes nothing. After a start the slave waits for an address, and after a stop it is idle.
- R12: The slave changes its drive of SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 4 | Frequency strap pins, captured after reset |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| freq_code | output | 4 | Selected frequency code |
| spread_en | output | 1 | Spread-spectrum enable |
| spread_down | output | 1 | Spread mode: 1 down spread, 0 center spread |
| outs_tristate | output | 1 | Request to tristate all clock outputs |
| cpu_en | output | 8 | Processor clock enable mask |
| pci_en | output | 8 | Peripheral bus clock enable mask |
| sdr_en | output | 8 | Upper memory clock enable mask |
| per_en | output | 8 | Memory, fixed-rate and reference clock enable mask |

## Verification
The assertions assume the following about the bus:
- SCL stays at each level for many system clocks, so every synchronised edge is seen once and the slave's SDA update settles before SCL rises again.
- The master never drives SDA low while the slave is driving.
- A stop is never issued while the slave holds SDA.

The bench drives SCL with a quarter period of five clocks. It changes SDA only in the low phase, except for deliberate start and stop conditions. It releases SDA during acknowledge bits and read bits, and it issues aborts only while the slave is receiving.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  localparam int STRAP_REG = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_ACK,
    ST_READ,
    ST_MACK
  } bus_state_t;

  function automatic logic [7:0] reg_default(int idx);
    return (idx == 0) ? 8'h20 : 8'hFF;
  endfunction

  function automatic logic [3:0] pick_freq(logic [7:0] r0, logic [3:0] strap);
    return r0[3] ? {r0[2], r0[6], r0[5], r0[4]} : strap;
  endfunction

  function automatic logic [7:0] strap_view(logic [7:0] r4, logic [3:0] strap);
    logic [7:0] v;
    v    = r4;
    v[3] = ~strap[1];
    v[1] = ~strap[3];
    return v;
  endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_chain;
  logic [SYNC_STAGES-1:0] sda_chain;
  logic scl_p;
  logic sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_p     <= 1'b1;
      sda_p     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
      scl_p     <= scl_chain[SYNC_STAGES-1];
      sda_p     <= sda_chain[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_chain[SYNC_STAGES-1];
  assign sda_s    = sda_chain[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 6,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int CNT_W = $clog2(NUM_REGS + 3) + 1,
  localparam int RP_W  = $clog2(NUM_REGS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             st_idle,
  output logic             st_addr
);

  bus_state_t       state;
  bus_state_t       after_ack;
  logic [2:0]       bitcnt;
  logic [7:0]       shreg;
  logic             ack_half;
  logic [CNT_W-1:0] wcnt;
  logic [RP_W-1:0]  rptr;
  logic             byte_done;
  logic [7:0]       full_byte;
  logic [7:0]       tx_byte;

  assign full_byte = {shreg[6:0], sda_s};
  assign byte_done = scl_rise && (bitcnt == 3'd7) &&
                     ((state == ST_ADDR) || (state == ST_WRITE));

  assign wr_en   = byte_done && (state == ST_WRITE) &&
                   (wcnt >= CNT_W'(2)) && ((wcnt - CNT_W'(2)) < CNT_W'(NUM_REGS));
  assign wr_idx  = IDX_W'(wcnt - CNT_W'(2));
  assign wr_data = full_byte;

  assign rd_idx = IDX_W'(rptr - RP_W'(1));

  always_comb begin
    if (rptr == '0) begin
      tx_byte = 8'(NUM_REGS);
    end else if (rptr <= RP_W'(NUM_REGS)) begin
      tx_byte = rd_data;
    end else begin
      tx_byte = 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ack_half  <= 1'b0;
      sda_oe    <= 1'b0;
      wcnt      <= '0;
      rptr      <= '0;
    end else if (start_ev) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      ack_half <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_ev) begin
      state    <= ST_IDLE;
      ack_half <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg  <= full_byte;
            bitcnt <= bitcnt + 3'd1;
            if (byte_done) begin
              if (full_byte[7:1] == DEV_ADDR) begin
                state     <= ST_ACK;
                after_ack <= full_byte[0] ? ST_READ : ST_WRITE;
                wcnt      <= '0;
                rptr      <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_WRITE: begin
          if (scl_rise) begin
            shreg  <= full_byte;
            bitcnt <= bitcnt + 3'd1;
            if (byte_done) begin
              state     <= ST_ACK;
              after_ack <= ST_WRITE;
              if (wcnt != '1) wcnt <= wcnt + CNT_W'(1);
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_half) begin
              sda_oe   <= 1'b1;
              ack_half <= 1'b1;
            end else begin
              ack_half <= 1'b0;
              state    <= after_ack;
              bitcnt   <= '0;
              sda_oe   <= (after_ack == ST_READ) ? ~tx_byte[7] : 1'b0;
            end
          end
        end
        ST_READ: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
          end else if (scl_fall) begin
            if (bitcnt == 3'd0) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              sda_oe <= ~tx_byte[3'd7 - bitcnt];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (!sda_s) begin
              if (rptr <= RP_W'(NUM_REGS)) rptr <= rptr + RP_W'(1);
            end else begin
              state <= ST_IDLE;
            end
          end else if (scl_fall) begin
            state  <= ST_READ;
            bitcnt <= '0;
            sda_oe <= ~tx_byte[7];
          end
        end
        default: ;
      endcase
    end
  end

  assign st_idle = (state == ST_IDLE);
  assign st_addr = (state == ST_ADDR);

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfgi2c_pkg::*;
#(
  parameter int NUM_REGS = 6,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       strap_i,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [3:0]       freq_code,
  output logic             spread_en,
  output logic             spread_down,
  output logic             outs_tristate,
  output logic [7:0]       cpu_en,
  output logic [7:0]       pci_en,
  output logic [7:0]       sdr_en,
  output logic [7:0]       per_en
);

  logic [7:0] regs [NUM_REGS];
  logic [3:0] strap_lat;
  logic       strap_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wr_en && (wr_idx == IDX_W'(i))) regs[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_lat   <= '0;
      strap_taken <= 1'b0;
    end else if (!strap_taken) begin
      strap_lat   <= strap_i;
      strap_taken <= 1'b1;
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_data = (i == STRAP_REG) ? strap_view(regs[i], strap_lat) : regs[i];
      end
    end
  end

  assign freq_code     = pick_freq(regs[0], strap_lat);
  assign spread_en     = regs[0][1];
  assign spread_down   = regs[0][7];
  assign outs_tristate = regs[0][0];
  assign cpu_en        = regs[1];
  assign pci_en        = regs[2];
  assign sdr_en        = regs[3];
  assign per_en        = regs[5];

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [3:0] strap_i,
  output logic       sda_oe,
  output logic [3:0] freq_code,
  output logic       spread_en,
  output logic       spread_down,
  output logic       outs_tristate,
  output logic [7:0] cpu_en,
  output logic [7:0] pci_en,
  output logic [7:0] sdr_en,
  output logic [7:0] per_en
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic             w_scl_s;
  logic             w_sda_s;
  logic             w_rise;
  logic             w_fall;
  logic             w_start;
  logic             w_stop;
  logic             w_wr_en;
  logic [IDX_W-1:0] w_wr_idx;
  logic [7:0]       w_wr_data;
  logic [IDX_W-1:0] w_rd_idx;
  logic [7:0]       w_rd_data;
  logic             w_idle;
  logic             w_addr;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (w_scl_s),
    .sda_s    (w_sda_s),
    .scl_rise (w_rise),
    .scl_fall (w_fall),
    .start_ev (w_start),
    .stop_ev  (w_stop)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (w_sda_s),
    .scl_rise (w_rise),
    .scl_fall (w_fall),
    .start_ev (w_start),
    .stop_ev  (w_stop),
    .rd_data  (w_rd_data),
    .rd_idx   (w_rd_idx),
    .sda_oe   (sda_oe),
    .wr_en    (w_wr_en),
    .wr_idx   (w_wr_idx),
    .wr_data  (w_wr_data),
    .st_idle  (w_idle),
    .st_addr  (w_addr)
  );

  cfg_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_i       (strap_i),
    .wr_en         (w_wr_en),
    .wr_idx        (w_wr_idx),
    .wr_data       (w_wr_data),
    .rd_idx        (w_rd_idx),
    .rd_data       (w_rd_data),
    .freq_code     (freq_code),
    .spread_en     (spread_en),
    .spread_down   (spread_down),
    .outs_tristate (outs_tristate),
    .cpu_en        (cpu_en),
    .pci_en        (pci_en),
    .sdr_en        (sdr_en),
    .per_en        (per_en)
  );

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int NUM_REGS = 6,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_s,
  input logic             ev_start,
  input logic             ev_stop,
  input logic             st_idle,
  input logic             st_addr,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [34:0]      cfg_flat
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe); // R2

  AST_START_ARMS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> st_addr); // R11

  AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> st_idle); // R11

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(NUM_REGS))); // R5

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_flat)); // R4

  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || $past(ev_start || ev_stop))); // R12

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_s    (w_scl_s),
  .ev_start (w_start),
  .ev_stop  (w_stop),
  .st_idle  (w_idle),
  .st_addr  (w_addr),
  .wr_en    (w_wr_en),
  .wr_idx   (w_wr_idx),
  .cfg_flat ({spread_en, spread_down, outs_tristate, cpu_en, pci_en, sdr_en, per_en})
);

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;

  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [3:0] strap = 4'h0;
  logic       sda_oe;
  logic       sda_bus;
  logic [3:0] freq_code;
  logic       spread_en, spread_down, outs_tristate;
  logic [7:0] cpu_en, pci_en, sdr_en, per_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int hi_changes = 0;

  logic [7:0] exp_r [6];
  logic [3:0] strap_v;
  logic [7:0] wbuf [10];
  logic [7:0] rbuf [10];

  assign sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  cfg_i2c_slave i_cfg_i2c_slave (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (m_scl),
    .sda_i         (sda_bus),
    .strap_i       (strap),
    .sda_oe        (sda_oe),
    .freq_code     (freq_code),
    .spread_en     (spread_en),
    .spread_down   (spread_down),
    .outs_tristate (outs_tristate),
    .cpu_en        (cpu_en),
    .pci_en        (pci_en),
    .sdr_en        (sdr_en),
    .per_en        (per_en)
  );

  // R12 monitor: SDA drive must not move while SCL is held high
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && (sda_oe != prev_oe)) hi_changes++;
    prev_oe  = sda_oe;
    prev_scl = m_scl;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [3:0] s);
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    strap = s;
    strap_v = s;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    exp_r[0] = 8'h20;
    for (int i = 1; i < 6; i++) exp_r[i] = 8'hFF;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_bus;  tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!give_ack);
  endtask

  function automatic logic [7:0] view(input int i);
    if (i == 4) return {exp_r[4][7:4], ~strap_v[1], exp_r[4][2], ~strap_v[3], exp_r[4][0]};
    if (i < 6) return exp_r[i];
    return 8'hFF;
  endfunction

  task automatic wr_block(input int n);
    bit a;
    bus_start();
    write_byte(8'hD2, a);
    chk(a, "R2 write address acknowledged", a, 1);
    write_byte(8'h3C, a);
    chk(a, "R3 command byte acknowledged", a, 1);
    write_byte(8'h01, a);
    chk(a, "R3 count byte acknowledged", a, 1);
    for (int i = 0; i < n; i++) begin
      write_byte(wbuf[i], a);
      chk(a, (i < 6) ? "R3 data byte acknowledged" : "R5 surplus byte acknowledged", a, 1);
      if (i < 6) exp_r[i] = (i == 4) ? {wbuf[i][7:4], exp_r[4][3], wbuf[i][2], exp_r[4][1], wbuf[i][0]} : wbuf[i];
    end
    bus_stop();
  endtask

  task automatic rd_block(input bit with_start, input int n, input string tag);
    bit a;
    logic [7:0] cnt;
    if (with_start) bus_start();
    write_byte(8'hD3, a);
    chk(a, "R2 read address acknowledged", a, 1);
    read_byte(1'b1, cnt);
    chk(cnt == 8'd6, "R6 byte count", cnt, 6);
    for (int i = 0; i < n; i++) read_byte(i != n - 1, rbuf[i]);
    bus_stop();
    for (int i = 0; i < n; i++) chk(rbuf[i] == view(i), tag, rbuf[i], view(i));
    chk(sda_bus == 1'b1, "R6 bus released after read", sda_bus, 1);
  endtask

  task automatic chk_outputs(input string note);
    logic [3:0] fexp;
    if (exp_r[0][3]) fexp = 4'((exp_r[0] >> 4) & 8'h7) + (exp_r[0][2] ? 4'd8 : 4'd0);
    else fexp = strap_v;
    chk(freq_code == fexp, {"R8 frequency code ", note}, freq_code, fexp);
    chk(spread_en == exp_r[0][1], {"R9 spread enable ", note}, spread_en, exp_r[0][1]);
    chk(spread_down == exp_r[0][7], {"R9 spread mode ", note}, spread_down, exp_r[0][7]);
    chk(outs_tristate == exp_r[0][0], {"R9 tristate ", note}, outs_tristate, exp_r[0][0]);
    chk({cpu_en, pci_en, sdr_en, per_en} == {exp_r[1], exp_r[2], exp_r[3], exp_r[5]},
        {"R10 enable masks ", note}, {cpu_en, pci_en, sdr_en, per_en},
        {exp_r[1], exp_r[2], exp_r[3], exp_r[5]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;

    // reset state
    do_reset(4'hA);
    chk({cpu_en, pci_en, sdr_en, per_en} == 32'hFFFF_FFFF, "R1 masks after reset",
        {cpu_en, pci_en, sdr_en, per_en}, 32'hFFFF_FFFF);
    chk({spread_en, spread_down, outs_tristate} == 3'b000, "R1 spread and tristate after reset",
        {spread_en, spread_down, outs_tristate}, 0);
    chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);
    chk_outputs("after reset");
    rd_block(1'b1, 6, "R1 reset readback");

    // strap sweep over every code
    for (int s = 0; s < 16; s++) begin
      do_reset(4'(s));
      chk(freq_code == 4'(s), "R8 strap selects frequency", freq_code, s);
      rd_block(1'b1, 5, "R7 strap readback in register 4");
    end

    // register-selected code sweep with the other register 0 fields
    do_reset(4'h5);
    for (int c = 0; c < 16; c++) begin
      logic [3:0] cv;
      cv = 4'(c);
      wbuf[0] = {cv[0], cv[2], cv[1], cv[0], 1'b1, cv[3], cv[1], cv[2]};
      wr_block(1);
      chk_outputs("code sweep");
    end

    // full write of all registers, read back
    wbuf[0] = 8'hA6; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
    wbuf[3] = 8'h0F; wbuf[4] = 8'h00; wbuf[5] = 8'h96;
    wr_block(6);
    chk_outputs("full write");
    rd_block(1'b1, 6, "R3 sequential readback");
    chk(exp_r[4] == 8'h0A, "R7 register 4 read-only bits kept", exp_r[4], 8'h0A);

    // partial write ends after two data bytes
    wbuf[0] = 8'h00; wbuf[1] = 8'h81;
    wr_block(2);
    chk_outputs("partial write");
    rd_block(1'b1, 6, "R4 partial write readback");

    // surplus bytes
    for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'h11 * (i + 1));
    wr_block(9);
    chk_outputs("surplus write");
    rd_block(1'b1, 8, "R5 surplus bytes discarded and R6 tail reads FF");

    // wrong addresses
    bus_start();
    write_byte(8'hD0, a);
    chk(!a, "R2 foreign address not acknowledged", a, 0);
    write_byte(8'h00, a);
    chk(!a, "R2 ignored until next start", a, 0);
    bus_stop();
    bus_start();
    write_byte(8'h52, a);
    chk(!a, "R2 upper-bit mismatch not acknowledged", a, 0);
    bus_stop();
    chk_outputs("after foreign address");

    // abort by repeated start in the middle of a data byte
    bus_start();
    write_byte(8'hD2, a);
    write_byte(8'h3C, a);
    write_byte(8'h01, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    rd_block(1'b0, 6, "R11 start abort leaves registers");
    chk_outputs("after start abort");

    // abort by stop in the middle of a data byte
    bus_start();
    write_byte(8'hD2, a);
    write_byte(8'h3C, a);
    write_byte(8'h01, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_stop();
    chk_outputs("R11 after stop abort");
    wbuf[0] = 8'h08; wbuf[1] = 8'h7E;
    wr_block(2);
    chk_outputs("R11 write after abort");

    chk(hi_changes == 0, "R12 SDA drive changes while SCL high", hi_changes, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule